// File: doc/BRIEF.md
# Restartable Micro-Op Expansion Sequencer

This block turns each accepted instruction into a short, ordered stream of wide micro-ops. A small built-in expansion rule stands in for decode. It reads a length field and an auxiliary-opcode base from the instruction word. From these it produces, for every step of the stream, an index, a per-step auxiliary opcode and the register-extension bits that steer each operand either to the architectural integer file or to private temporaries. Micro-ops leave through a valid/ready handshake. A new instruction is taken only once the whole stream has been handed off.

Interrupts are taken between micro-ops, not at instruction boundaries. When `irq_take` is raised, the stream in flight is dropped at once. The sequencer then records a fixed-point saved PC: the instruction address sits in the upper bits, and the 3-bit index of the first step not yet really performed fills the low bits. Those low bits replace the address's two always-zero bits plus one extra bit. To resume, software feeds that index back in as `in_resume`. The sequencer then replays the stream from step 0 so that indexing stays aligned, but it flags every step below the resume index as a NOP by clearing its live bit.

The control is a two-state machine. **IDLE** waits for an instruction. The IDLE→ISSUE transition (*accept*) fires on `in_valid && in_ready`. **ISSUE** presents one micro-op per handoff. It returns to IDLE either on *finish*, when the last step is handed off, or on *abort*, when `irq_take` is high, which has priority over the handoff.

Top module: `uop_expander`

## Requirements
- R1: After reset `uop_valid` is 0, `in_ready` is 1 and `saved_pc` is 0.
- R2: `in_ready` is 1 only in IDLE while `irq_take` is 0; an instruction is accepted when `in_valid` and `in_ready` are both 1, and its first micro-op is presented in the next cycle.
- R3: The stream length is `in_insn[30:28]` + 1 (1 to 8); `uop_cnt` reports length − 1, `uop_idx` steps 0,1,… up to `uop_cnt` one per handoff, and after the last handoff the block is idle in the next cycle.
- R4: `uop_aux` equals (`in_insn[27:24]` + `uop_idx`) mod 16, and `uop_insn` carries the accepted instruction word unchanged.
- R5: Extension bits: `uop_ext_rd` is 01 (temporary) on every step except the last, where it is 00 (architectural); `uop_ext_rs1` is 00 on step 0 and 01 afterwards; `uop_ext_rs2` is always 00.
- R6: Steps whose index is below the accepted `in_resume` value are presented with `uop_live` = 0 (NOP); all other steps have `uop_live` = 1.
- R7: While `uop_valid` is 1 and `uop_ready` is 0, every micro-op output holds its value, `in_ready` stays 0, and an offered instruction is not taken.
- R8: When `irq_take` is 1 during ISSUE, `uop_valid` is 0 in that cycle (no handoff). The block is idle in the next cycle, and `saved_pc` then equals {address[31:2], max(current index, resume index)}.
- R9: When `irq_take` is 1 in IDLE, `saved_pc` in the next cycle is {A[31:2], 000}, where A is the address of the last completed instruction plus 4 (0 if none). `saved_pc` changes only in the cycle after `irq_take`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer can take an instruction |
| in_insn | input | 32 | Instruction word |
| in_addr | input | 32 | Instruction address |
| in_resume | input | 3 | First step to perform for real |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_live | output | 1 | 1 = real step, 0 = NOP placeholder |
| uop_cnt | output | 3 | Stream length minus one |
| uop_idx | output | 3 | Index of this step |
| uop_aux | output | 4 | Auxiliary opcode of this step |
| uop_ext_rd | output | 2 | Destination register extension |
| uop_ext_rs1 | output | 2 | Source 1 register extension |
| uop_ext_rs2 | output | 2 | Source 2 register extension |
| uop_insn | output | 32 | Original instruction word |
| irq_take | input | 1 | Take an interrupt now |
| saved_pc | output | 33 | Fixed-point restart PC |

## Verification
The properties assume that `irq_take` is a single-cycle pulse and that `in_resume` only ever holds an index the sequencer itself reported earlier or 0. With these assumptions, a handoff is always followed either by the next step or by an abort. The stimulus raises `irq_take` for exactly one cycle at a time, and keeps `in_valid` low after an accept except for a deliberate offer during a stall. It sweeps every length, with every resume value for complete streams and every abort position for interrupted ones.

// File: rtl/uopx_pkg.sv
package uopx_pkg;

    localparam int IDX_W = 3;
    localparam int AUX_W = 4;
    localparam int EXT_W = 2;

    localparam logic [EXT_W-1:0] EXT_ARCH = 2'b00;
    localparam logic [EXT_W-1:0] EXT_TEMP = 2'b01;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic             live;
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [AUX_W-1:0] aux;
        logic [EXT_W-1:0] ext_rd;
        logic [EXT_W-1:0] ext_rs1;
        logic [EXT_W-1:0] ext_rs2;
    } uop_ctl_t;

endpackage

// File: rtl/uopx_table.sv
module uopx_table
    import uopx_pkg::*;
(
    input  logic [IDX_W-1:0] len_m1,
    input  logic [AUX_W-1:0] aux_base,
    input  logic [IDX_W-1:0] step,
    input  logic [IDX_W-1:0] resume,
    output uop_ctl_t         ctl
);

    logic is_last;
    logic is_first;

    always_comb begin
        is_last     = (step == len_m1);
        is_first    = (step == '0);
        ctl.live    = (step >= resume);
        ctl.cnt     = len_m1;
        ctl.idx     = step;
        ctl.aux     = aux_base + AUX_W'(step);
        ctl.ext_rd  = is_last  ? EXT_ARCH : EXT_TEMP;
        ctl.ext_rs1 = is_first ? EXT_ARCH : EXT_TEMP;
        ctl.ext_rs2 = EXT_ARCH;
    end

endmodule

// File: rtl/uopx_fold.sv
module uopx_fold
    import uopx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-3:0] word_addr,
    input  logic [IDX_W-1:0]  step,
    output logic [ADDR_W:0]   folded
);

    assign folded = {word_addr, step};

endmodule

// File: rtl/uop_expander.sv
module uop_expander
    import uopx_pkg::*;
#(
    parameter int INSN_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int LEN_LSB = 28,
    parameter int AUX_LSB = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [IDX_W-1:0]  in_resume,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic              uop_live,
    output logic [IDX_W-1:0]  uop_cnt,
    output logic [IDX_W-1:0]  uop_idx,
    output logic [AUX_W-1:0]  uop_aux,
    output logic [EXT_W-1:0]  uop_ext_rd,
    output logic [EXT_W-1:0]  uop_ext_rs1,
    output logic [EXT_W-1:0]  uop_ext_rs2,
    output logic [INSN_W-1:0] uop_insn,
    input  logic              irq_take,
    output logic [ADDR_W:0]   saved_pc
);

    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [INSN_W-1:0] insn_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] nxt_addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  res_q;
    logic [ADDR_W:0]   saved_q;

    uop_ctl_t          ctl;
    logic              accept;
    logic              handoff;
    logic              at_last;
    logic [IDX_W-1:0]  rec_idx;
    logic [ADDR_W:0]   fold_abort;
    logic [ADDR_W:0]   fold_idle;

    uopx_table u_table (
        .len_m1   (insn_q[LEN_LSB +: IDX_W]),
        .aux_base (insn_q[AUX_LSB +: AUX_W]),
        .step     (idx_q),
        .resume   (res_q),
        .ctl      (ctl)
    );

    assign rec_idx = (idx_q >= res_q) ? idx_q : res_q;

    uopx_fold #(.ADDR_W(ADDR_W)) u_fold_abort (
        .word_addr (addr_q[ADDR_W-1:2]),
        .step      (rec_idx),
        .folded    (fold_abort)
    );

    uopx_fold #(.ADDR_W(ADDR_W)) u_fold_idle (
        .word_addr (nxt_addr_q[ADDR_W-1:2]),
        .step      ('0),
        .folded    (fold_idle)
    );

    // Output process: handshakes from the state.
    always_comb begin
        in_ready  = 1'b0;
        uop_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_ready  = !irq_take;
            ST_ISSUE: uop_valid = !irq_take;
            default:  ;
        endcase
    end

    assign accept  = in_valid && in_ready;
    assign handoff = uop_valid && uop_ready;
    assign at_last = (idx_q == ctl.cnt);

    // Next-state logic: accept, finish, abort.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: if (irq_take || (handoff && at_last)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Stream context and restart record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q     <= '0;
            addr_q     <= '0;
            nxt_addr_q <= '0;
            idx_q      <= '0;
            res_q      <= '0;
            saved_q    <= '0;
        end else begin
            if (accept) begin
                insn_q <= in_insn;
                addr_q <= in_addr;
                idx_q  <= '0;
                res_q  <= in_resume;
            end else if (handoff && !at_last) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            if (handoff && at_last) nxt_addr_q <= addr_q + INSN_BYTES;
            if (irq_take) saved_q <= (state_q == ST_ISSUE) ? fold_abort : fold_idle;
        end
    end

    assign uop_live    = ctl.live;
    assign uop_cnt     = ctl.cnt;
    assign uop_idx     = ctl.idx;
    assign uop_aux     = ctl.aux;
    assign uop_ext_rd  = ctl.ext_rd;
    assign uop_ext_rs1 = ctl.ext_rs1;
    assign uop_ext_rs2 = ctl.ext_rs2;
    assign uop_insn    = insn_q;
    assign saved_pc    = saved_q;

endmodule

// File: rtl/uopx_checker.sv
module uopx_checker
    import uopx_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              uop_valid,
    input logic              uop_ready,
    input logic              uop_live,
    input logic [IDX_W-1:0]  uop_cnt,
    input logic [IDX_W-1:0]  uop_idx,
    input logic [EXT_W-1:0]  uop_ext_rd,
    input logic [INSN_W-1:0] uop_insn,
    input logic              irq_take,
    input logic [ADDR_W:0]   saved_pc
);

    // R2
    hs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && uop_valid));

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> (uop_idx <= uop_cnt));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && (uop_idx != uop_cnt))
        |=> (irq_take || (uop_valid && (uop_idx == $past(uop_idx) + 3'd1))));

    // R3
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_ready && (uop_idx == uop_cnt)) |=> !uop_valid);

    // R5
    last_arch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && (uop_idx == uop_cnt)) |-> (uop_ext_rd == 2'b00));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready)
        |=> ($stable(uop_idx) && $stable(uop_insn) && $stable(uop_live) && !in_ready));

    // R8
    abort_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !uop_valid);

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !uop_valid);

    // R9
    saved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |=> $stable(saved_pc));

endmodule

bind uop_expander uopx_checker #(.INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .uop_valid  (uop_valid),
    .uop_ready  (uop_ready),
    .uop_live   (uop_live),
    .uop_cnt    (uop_cnt),
    .uop_idx    (uop_idx),
    .uop_ext_rd (uop_ext_rd),
    .uop_insn   (uop_insn),
    .irq_take   (irq_take),
    .saved_pc   (saved_pc)
);

// File: tb/tb_uop_expander.sv
module tb_uop_expander;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_insn;
    logic [31:0] in_addr;
    logic [2:0]  in_resume;
    logic        uop_valid;
    logic        uop_ready;
    logic        uop_live;
    logic [2:0]  uop_cnt;
    logic [2:0]  uop_idx;
    logic [3:0]  uop_aux;
    logic [1:0]  uop_ext_rd;
    logic [1:0]  uop_ext_rs1;
    logic [1:0]  uop_ext_rs2;
    logic [31:0] uop_insn;
    logic        irq_take;
    logic [32:0] saved_pc;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    uop_expander dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
        .in_addr(in_addr), .in_resume(in_resume),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_live(uop_live),
        .uop_cnt(uop_cnt), .uop_idx(uop_idx), .uop_aux(uop_aux),
        .uop_ext_rd(uop_ext_rd), .uop_ext_rs1(uop_ext_rs1), .uop_ext_rs2(uop_ext_rs2),
        .uop_insn(uop_insn), .irq_take(irq_take), .saved_pc(saved_pc)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input int len, input int auxb, input int salt);
        logic [2:0]  l = 3'(len - 1);
        logic [3:0]  a = 4'(auxb);
        logic [23:0] s = 24'(salt * 24'h01F3A7 + 24'h5A0C11);
        return {1'b0, l, a, s};
    endfunction

    // Micro-op fields expected for step k of a stream.
    task automatic check_uop(input int k, input int len, input int res, input logic [31:0] w);
        logic [3:0] exp_aux = 4'(w[27:24] + 4'(k));
        logic [1:0] exp_rd  = (k == len - 1) ? 2'b00 : 2'b01;
        logic [1:0] exp_rs1 = (k == 0) ? 2'b00 : 2'b01;
        chk(uop_valid == 1'b1, "R3 valid", uop_valid, 1);
        chk(uop_idx == 3'(k), "R3 idx", uop_idx, k);
        chk(uop_cnt == 3'(len - 1), "R3 cnt", uop_cnt, len - 1);
        chk(uop_aux == exp_aux, "R4 aux", uop_aux, exp_aux);
        chk(uop_insn == w, "R4 insn", uop_insn, w);
        chk(uop_ext_rd == exp_rd, "R5 ext_rd", uop_ext_rd, exp_rd);
        chk(uop_ext_rs1 == exp_rs1, "R5 ext_rs1", uop_ext_rs1, exp_rs1);
        chk(uop_ext_rs2 == 2'b00, "R5 ext_rs2", uop_ext_rs2, 0);
        chk(uop_live == (k >= res), "R6 live", uop_live, (k >= res));
    endtask

    // Starts just after a falling edge; ends just after a falling edge, DUT in ISSUE.
    task automatic send(input logic [31:0] w, input logic [31:0] a, input int res);
        in_valid  = 1'b1;
        in_insn   = w;
        in_addr   = a;
        in_resume = 3'(res);
        #1;
        chk(in_ready == 1'b1, "R2 ready in idle", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_insn  = '0;
    endtask

    task automatic irq_pulse();
        irq_take  = 1'b1;
        uop_ready = 1'b1;
        #1;
        chk(uop_valid == 1'b0, "R8 no handoff on irq", uop_valid, 0);
        chk(in_ready == 1'b0, "R2 no accept on irq", in_ready, 0);
        @(posedge clk);
        @(negedge clk);
        irq_take  = 1'b0;
        uop_ready = 1'b0;
        #1;
    endtask

    task automatic do_stream(input int len, input int res, input bit stall, input logic [31:0] a);
        logic [31:0] w = mk_insn(len, len * 3 + res, len * 8 + res);
        logic [32:0] exp_pc;
        send(w, a, res);
        for (int k = 0; k < len; k++) begin
            if (stall) begin
                uop_ready = 1'b0;
                in_valid  = 1'b1;
                in_insn   = ~w;
                #1;
                check_uop(k, len, res, w);
                chk(in_ready == 1'b0, "R7 ready low in stall", in_ready, 0);
                @(negedge clk);
                in_valid = 1'b0;
                #1;
                check_uop(k, len, res, w);
            end
            uop_ready = 1'b1;
            #1;
            check_uop(k, len, res, w);
            @(posedge clk);
            @(negedge clk);
        end
        uop_ready = 1'b0;
        #1;
        chk(uop_valid == 1'b0, "R3 idle after last", uop_valid, 0);
        chk(in_ready == 1'b1, "R3 ready after last", in_ready, 1);
        irq_pulse();
        exp_pc = {a[31:2] + 30'd1, 3'b000};
        chk(saved_pc == exp_pc, "R9 idle saved_pc", saved_pc, exp_pc);
    endtask

    task automatic irq_stream(input int len, input int res, input int p, input logic [31:0] a);
        logic [31:0] w = mk_insn(len, p + 5, len * 16 + p * 4 + res);
        int          rec = (p >= res) ? p : res;
        logic [32:0] exp_pc = {a[31:2], 3'(rec)};
        send(w, a, res);
        for (int k = 0; k < p; k++) begin
            uop_ready = 1'b1;
            #1;
            check_uop(k, len, res, w);
            @(posedge clk);
            @(negedge clk);
        end
        irq_pulse();
        chk(saved_pc == exp_pc, "R8 abort saved_pc", saved_pc, exp_pc);
        chk(uop_valid == 1'b0, "R8 idle after abort", uop_valid, 0);
        chk(in_ready == 1'b1, "R8 ready after abort", in_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_insn   = '0;
        in_addr   = '0;
        in_resume = '0;
        uop_ready = 1'b0;
        irq_take  = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(uop_valid == 1'b0, "R1 valid", uop_valid, 0);
        chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
        chk(saved_pc == '0, "R1 saved_pc", saved_pc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        irq_pulse();
        chk(saved_pc == '0, "R9 idle irq before any insn", saved_pc, 0);

        for (int len = 1; len <= 8; len++) begin
            for (int res = 0; res < 8; res++) begin
                do_stream(len, res, ((len + res) % 3) == 0,
                          32'h4000_0000 + 32'(len * 256 + res * 16) + 32'(res[0]) * 32'hC);
            end
        end

        for (int len = 1; len <= 8; len++) begin
            for (int p = 0; p < len; p++) begin
                for (int r = 0; r < 3; r++) begin
                    irq_stream(len, r * 3, p, 32'h8000_1000 + 32'(len * 64 + p * 8) + 32'(r) * 32'h1_0000);
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule